// File: doc/BRIEF.md
# Condition-to-Boolean Result Generator

This block turns the state of a 32-bit condition register into a 64-bit integer result. It offers one field operation and four single-bit operations. The field operation reads a whole 4-bit condition field and yields a three-way signum: -1, +1 or 0. The single-bit operations test one condition bit. They return a positive boolean (1) or a negative boolean (all ones), in either the normal or the reversed sense.

An execution pipeline presents an operation code, the condition register contents, a field index and a bit index, and marks them with an input strobe. The result is registered, and it comes back one clock later together with a valid flag. Updating the condition register and writing the result to a register file are left to neighbouring logic.

Top module: `cond_bool_gen`

## Requirements
- R1: While reset is asserted (active low), `outValid` is 0 and `result` is all zeros.
- R2: `outValid` is 1 in exactly the cycle after each cycle in which `inValid` was 1, and 0 otherwise. `result` carries the answer for the operands sampled in that cycle.
- R3: Operation code 000 (field signum): field k covers `condReg[31-4k:28-4k]`. When its most significant bit, `condReg[31-4k]`, is 1, the result is all ones, whatever the other three bits are.
- R4: Operation code 000: when `condReg[31-4k]` is 0 and `condReg[30-4k]` is 1, the result is 1. When both are 0, the result is 0. The two low bits of the field never affect the result.
- R5: The single-bit operations test bit index b as `condReg[31-b]`, counted from the MSB (b=0 is `condReg[31]`, b=31 is `condReg[0]`).
- R6: Operation code 001: the result is 1 when the tested bit is 1, and 0 when it is 0.
- R7: Operation code 010: the result is 0 when the tested bit is 1, and 1 when it is 0.
- R8: Operation code 011: the result is all ones when the tested bit is 1, and 0 when it is 0.
- R9: Operation code 100: the result is 0 when the tested bit is 1, and all ones when it is 0.
- R10: Operation codes 101, 110 and 111 give an all-zero result, with `outValid` raised as usual.
- R11: In a cycle with `inValid` at 0, changes on `opCode`, `condReg`, `fieldIdx` and `bitIdx` leave `result` unchanged in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands valid this cycle |
| opCode | input | 3 | Operation select |
| condReg | input | 32 | Condition register contents |
| fieldIdx | input | 3 | Field index for the signum operation |
| bitIdx | input | 5 | Bit index for the single-bit operations |
| outValid | output | 1 | Result valid |
| result | output | 64 | Registered 64-bit result |

## Verification
The bench sets the less-than and greater-than bits of a field together, and expects -1. A design that tests the bits in the wrong order would return +1 here. It also fills the two low bits of a field while the upper two are clear. A design that reads the wrong pair of bits would then return a nonzero value. Bit indices 0 and 31, and fields 0 and 7, catch LSB-first numbering, which tests the mirror-image bit. Every polarity is tried with the tested bit both set and clear, so a swapped sense or a 1 given in place of all ones shows up as a miscompare. The bench also toggles the operands while the strobe is low and checks that the result holds, so a design that loads without the strobe is caught.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int CR_W    = 32;
  localparam int FIELD_W = 4;
  localparam int RES_W   = 64;

  typedef enum logic [2:0] {
    OP_SIGNUM = 3'b000,
    OP_SET    = 3'b001,
    OP_SETR   = 3'b010,
    OP_NEG    = 3'b011,
    OP_NEGR   = 3'b100
  } op_e;

  typedef struct packed {
    logic load;      // capture a new result
    logic useField;  // three-way signum over a field
    logic allOnes;   // true value is all ones rather than 1
    logic invert;    // reversed sense of the tested bit
    logic zeroOut;   // unsupported code: force zero
  } ctrl_t;
endpackage

// File: rtl/cbg_ctrl.sv
module cbg_ctrl
  import cbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [2:0] opCode,
  output ctrl_t      ctrl,
  output logic       outValid
);
  always_comb begin
    ctrl      = '0;
    ctrl.load = inValid;
    case (opCode)
      OP_SIGNUM: ctrl.useField = 1'b1;
      OP_SET:    ;
      OP_SETR:   ctrl.invert = 1'b1;
      OP_NEG:    ctrl.allOnes = 1'b1;
      OP_NEGR: begin
        ctrl.allOnes = 1'b1;
        ctrl.invert  = 1'b1;
      end
      default:   ctrl.zeroOut = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/cbg_datapath.sv
module cbg_datapath
  import cbg_pkg::*;
#(
  parameter int CRW  = CR_W,
  parameter int FW   = FIELD_W,
  parameter int RW   = RES_W,
  localparam int NF   = CRW / FW,
  localparam int FI_W = $clog2(NF),
  localparam int BI_W = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctrl,
  input  logic [CRW-1:0]  condReg,
  input  logic [FI_W-1:0] fieldIdx,
  input  logic [BI_W-1:0] bitIdx,
  output logic [RW-1:0]   result
);
  logic [NF-1:0]  fieldLt;
  logic [NF-1:0]  fieldGt;
  logic [CRW-1:0] crMsb;

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign fieldLt[f] = condReg[CRW-1-FW*f];
    assign fieldGt[f] = condReg[CRW-2-FW*f];
  end

  for (genvar i = 0; i < CRW; i++) begin : g_msb
    assign crMsb[i] = condReg[CRW-1-i];
  end

  logic          hit;
  logic [RW-1:0] nextRes;

  always_comb begin
    hit = crMsb[bitIdx] ^ ctrl.invert;
    if (ctrl.zeroOut)
      nextRes = '0;
    else if (ctrl.useField)
      nextRes = fieldLt[fieldIdx] ? '1 :
                (fieldGt[fieldIdx] ? RW'(1) : '0);
    else if (hit)
      nextRes = ctrl.allOnes ? '1 : RW'(1);
    else
      nextRes = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         result <= '0;
    else if (ctrl.load) result <= nextRes;
  end
endmodule

// File: rtl/cond_bool_gen.sv
module cond_bool_gen
  import cbg_pkg::*;
#(
  parameter int CRW  = CR_W,
  parameter int FW   = FIELD_W,
  parameter int RW   = RES_W,
  localparam int NF   = CRW / FW,
  localparam int FI_W = $clog2(NF),
  localparam int BI_W = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic [2:0]      opCode,
  input  logic [CRW-1:0]  condReg,
  input  logic [FI_W-1:0] fieldIdx,
  input  logic [BI_W-1:0] bitIdx,
  output logic            outValid,
  output logic [RW-1:0]   result
);
  ctrl_t ctrl;

  cbg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .opCode   (opCode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  cbg_datapath #(.CRW(CRW), .FW(FW), .RW(RW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .condReg  (condReg),
    .fieldIdx (fieldIdx),
    .bitIdx   (bitIdx),
    .result   (result)
  );
endmodule

// File: rtl/cbg_checker.sv
module cbg_checker #(
  parameter int CRW  = 32,
  parameter int FW   = 4,
  parameter int RW   = 64,
  localparam int NF   = CRW / FW,
  localparam int FI_W = $clog2(NF),
  localparam int BI_W = $clog2(CRW)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inValid,
  input logic [2:0]      opCode,
  input logic [CRW-1:0]  condReg,
  input logic [FI_W-1:0] fieldIdx,
  input logic [BI_W-1:0] bitIdx,
  input logic            outValid,
  input logic [RW-1:0]   result
);
  logic ltSel, bitSel;
  assign ltSel  = condReg[CRW-1-FW*int'(fieldIdx)];
  assign bitSel = condReg[CRW-1-int'(bitIdx)];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  a_r3_lt_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 3'b000 && ltSel) |=> (result == {RW{1'b1}}));
  a_r6_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode == 3'b001) |=> (result == RW'($past(bitSel))));
  a_r10_bad_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opCode > 3'b100) |=> (result == '0));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));
endmodule

bind cond_bool_gen cbg_checker #(.CRW(CRW), .FW(FW), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .opCode   (opCode),
  .condReg  (condReg),
  .fieldIdx (fieldIdx),
  .bitIdx   (bitIdx),
  .outValid (outValid),
  .result   (result)
);

// File: tb/cond_bool_gen_test.sv
module cond_bool_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] condReg = '0;
  logic [2:0]  fieldIdx = '0;
  logic [4:0]  bitIdx = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  cond_bool_gen uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opCode(opCode),
    .condReg(condReg), .fieldIdx(fieldIdx), .bitIdx(bitIdx),
    .outValid(outValid), .result(result)
  );

  function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] cr,
                                        input int f, input int b);
    logic lt, gt, tb;
    lt = cr[31-4*f];
    gt = cr[30-4*f];
    tb = cr[31-b];
    case (op)
      3'b000:  return lt ? '1 : (gt ? 64'd1 : 64'd0);
      3'b001:  return tb ? 64'd1 : 64'd0;
      3'b010:  return tb ? 64'd0 : 64'd1;
      3'b011:  return tb ? '1 : 64'd0;
      3'b100:  return tb ? 64'd0 : '1;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one operation per call, strobe left high for back-to-back use
  task automatic apply(input logic [2:0] op, input logic [31:0] cr,
                       input int f, input int b, input string tag);
    @(negedge clk);
    opCode = op; condReg = cr; fieldIdx = 3'(f); bitIdx = 5'(b); inValid = 1'b1;
    expQ.push_back(model(op, cr, f, b));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) check("R2 outValid without request", 64'd1, 64'd0);
        else check(tagQ.pop_front(), result, expQ.pop_front());
      end else if (expQ.size() != 0 && !inValid) begin
        check("R2 missing outValid", 64'd0, 64'd1);
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 64'd0);
    check("R1 reset outValid", 64'(outValid), 64'd0);
    rst_n = 1'b1;
    idle(1);

    // field signum: R3, R4
    apply(3'b000, 32'hC000_0000, 0, 0, "R3 field0 lt+gt");
    apply(3'b000, 32'h4000_0000, 0, 0, "R4 field0 gt");
    apply(3'b000, 32'h3000_0000, 0, 0, "R4 field0 low bits only");
    apply(3'b000, 32'h0000_0008, 7, 0, "R3 field7 lt");
    apply(3'b000, 32'h0000_0004, 7, 0, "R4 field7 gt");
    apply(3'b000, 32'hFFFF_FF3F, 6, 0, "R4 field6 zero");
    apply(3'b000, 32'h0008_0000, 3, 0, "R3 field3 lt");
    idle(2);

    // bit ordering R5 and polarities R6..R9
    for (int op = 1; op <= 4; op++) begin
      string tg;
      tg = (op == 1) ? "R6" : (op == 2) ? "R7" : (op == 3) ? "R8" : "R9";
      apply(3'(op), 32'h8000_0000, 0,  0,  {tg, " R5 bit0 set"});
      apply(3'(op), 32'h7FFF_FFFF, 0,  0,  {tg, " R5 bit0 clear"});
      apply(3'(op), 32'h0000_0001, 0,  31, {tg, " R5 bit31 set"});
      apply(3'(op), 32'hFFFF_FFFE, 0,  31, {tg, " R5 bit31 clear"});
      apply(3'(op), 32'h0001_0000, 0,  15, {tg, " bit15 set"});
    end
    idle(2);

    // unsupported codes R10
    for (int op = 5; op <= 7; op++)
      apply(3'(op), 32'hFFFF_FFFF, 0, 0, "R10 unsupported code");
    idle(2);

    // hold while strobe low R11
    apply(3'b011, 32'h8000_0000, 0, 0, "R8 before hold");
    idle(2);
    held = result;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      opCode = 3'(i); condReg = ~condReg; bitIdx = 5'(i * 7); fieldIdx = 3'(i);
      @(negedge clk);
      check("R11 hold result", result, held);
      check("R11 hold outValid", 64'(outValid), 64'd0);
    end

    // mixed sweep
    for (int i = 0; i < 300; i++)
      apply(3'($urandom_range(0, 7)), $urandom, $urandom_range(0, 7),
            $urandom_range(0, 31), "R2 sweep");
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule